// File: doc/BRIEF.md
# Message-Passing Network Interface Packetizer

This block connects a processor core to an on-chip network router. The core issues one command at a time: open a connection, send a 16-bit word, close the connection, acknowledge a received message, read an arrived flit, read the local node number, or read a status flag. The block turns send commands into 17-bit flits on a valid/ready output. Arriving flits are held in a small FIFO until the core reads them.

A connection is opened by a typed header flit and stays open until a constant tail flit closes it. Data words may only be sent while a connection is open. A send command that breaks this ordering is flagged and sends nothing. When the block cannot finish a command in the cycle it is presented, it raises `busy` and the core holds the command. This happens when the output flit slot is still occupied, or when a read finds the receive FIFO empty.

Commands use these `cmd_op` codes: 0 none, 1 send-header, 2 send-word, 3 send-tail, 4 send-acknowledge, 5 receive, 6 get-id, 7 get-flag. A command is accepted on a rising clock edge where `cmd_valid` is high and `busy` is low. A read command puts its result on `rd_data`, with `rd_valid` high, for the one cycle after acceptance.

Top module: `mpni_packetizer`

## Requirements
- R1: An accepted send-header in the idle state emits the flit {1'b1, opa[4:0], 3'b000, kind[2:0], opb[4:0]} and moves the sender to the open state.
- R2: Header kinds 0 to 4 are legal: 0 buffer, 1 packet channel, 2 16-bit scalar, 3 32-bit scalar, 4 64-bit scalar. A send-header with kind 5, 6 or 7 is a protocol error and sends nothing. A send-header issued while a connection is already open is also a protocol error and sends nothing.
- R3: An accepted send-word in the open state emits {1'b0, opa[15:0]}. The upper operand bits are ignored.
- R4: An accepted send-tail in the open state emits 17'h10400, which has only bits 16 and 10 set, and returns the sender to the idle state.
- R5: A send-word or send-tail in the idle state sends nothing and sets the protocol-error flag. Every accepted send command updates this flag, so the next legal send command clears it.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_flit` holds its value and every send command stalls with `busy` high. Each accepted legal send produces exactly one flit. After reset `tx_valid` is 0.
- R7: Send-acknowledge is legal in either state. It emits {1'b1, S, 3'b000, 3'b111, node_id}, where S is bits 4:0 of the most recently read header flit (0 after reset). It does not change the sender state.
- R8: Arriving flits are stored in a 4-entry FIFO and read in arrival order. `rx_ready` is low exactly while the FIFO is full, and it is 1 after reset.
- R9: A receive command returns the oldest stored flit, zero-extended to 32 bits. While the FIFO is empty, a receive stalls with `busy` high until a flit arrives.
- R10: Get-id returns `node_id` zero-extended to 32 bits.
- R11: Get-flag returns the flag selected by `cmd_imm` in bit 0 and zeros above. The indices are: 0 receive data available, 1 connection open, 2 protocol error, 3 last read flit was a header, 4 last read flit was a tail, 5 last read flit was data, 6 output flit pending. Any index from 7 up reads 0.
- R12: The class of a read flit is decided as follows: data when bit 16 is 0, tail when bits 16 and 10 are both 1, header when bit 16 is 1 and bit 10 is 0. At most one class flag is set at a time, and all three are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_id | input | 5 | Local node number |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_kind | input | 3 | Header kind for send-header |
| cmd_opa | input | 32 | First register operand |
| cmd_opb | input | 32 | Second register operand |
| cmd_imm | input | 4 | Flag index for get-flag |
| busy | output | 1 | Command cannot be accepted this cycle |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 32 | Read result |
| tx_flit | output | 17 | Outgoing flit |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Router accepts the flit |
| rx_flit | input | 17 | Incoming flit |
| rx_valid | input | 1 | Incoming flit valid |
| rx_ready | output | 1 | Block accepts the incoming flit |

## Verification
Send traffic is first tried with the router always ready, then with a router that accepts only one cycle in three. This shows whether stalled flits are held and delivered once each, or are dropped or repeated. Every header kind is sent, together with illegal kinds and out-of-order word, tail and header commands, so that legal framing can be told apart from rejected commands. On the receive side, the FIFO is filled to capacity and then drained with a header, data, tail and data mix, which checks ordering, the full condition and the three class flags. A receive issued on an empty FIFO shows the stall and its release when a flit arrives. The acknowledge addresses the sender taken from the last header that was read.

// File: rtl/mpni_pkg.sv
// Shared types and flit encodings for the network interface packetizer.
package mpni_pkg;
    localparam int FLIT_W = 17;
    localparam int WORD_W = 16;
    localparam int NODE_W = 5;
    localparam int KIND_W = 3;

    typedef logic [FLIT_W-1:0] flit_t;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_SEND_HDR  = 3'd1,
        OP_SEND_WORD = 3'd2,
        OP_SEND_TAIL = 3'd3,
        OP_SEND_ACK  = 3'd4,
        OP_RECV      = 3'd5,
        OP_GET_ID    = 3'd6,
        OP_GET_FLAG  = 3'd7
    } op_e;

    typedef enum logic {TX_IDLE = 1'b0, TX_OPEN = 1'b1} tx_state_e;

    localparam flit_t             TAIL_FLIT     = 17'h10400;
    localparam logic [KIND_W-1:0] ACK_KIND      = 3'd7;
    localparam logic [KIND_W-1:0] MAX_HDR_KIND  = 3'd4;

    // Build a control flit that opens a connection or carries an acknowledge.
    function automatic flit_t make_header(input logic [NODE_W-1:0] dest,
                                          input logic [KIND_W-1:0] kind,
                                          input logic [NODE_W-1:0] src);
        return {1'b1, dest, 3'b000, kind, src};
    endfunction
endpackage

// File: rtl/mpni_rx_fifo.sv
// Receive flit FIFO.
// Stores incoming flits in arrival order and presents the oldest one at
// `head`. It accepts a flit only while it is not full. It assumes `pop` is
// raised only while it is not empty. The depth need not be a power of two.
module mpni_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             push, full;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign in_ready = !full;
    assign push     = in_valid && in_ready;
    assign head     = mem[rptr];

    // Write the accepted flit into the storage slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= in_data;
    end

    // Advance both pointers with wrap and track the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> full); // R8
endmodule

// File: rtl/mpni_tx_seq.sv
// Send sequencer and output flit slot.
// Checks each accepted send command against the connection state, forms the
// flit and places it in a single output register held under valid/ready.
// It assumes `launch` is raised only when `slot_free` is high. An illegal
// command consumes the accept but writes no flit.
module mpni_tx_seq
    import mpni_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  op_e               op,
    input  logic [KIND_W-1:0] kind,
    input  logic [WORD_W-1:0] opa_lo,
    input  logic [NODE_W-1:0] opb_lo,
    input  logic [NODE_W-1:0] ack_dest,
    input  logic [NODE_W-1:0] node_id,
    input  logic              tx_ready,
    output flit_t             tx_flit,
    output logic              tx_valid,
    output logic              slot_free,
    output logic              conn_open,
    output logic              proto_err
);
    tx_state_e state;
    logic      legal;
    flit_t     next_flit;

    assign slot_free = !tx_valid || tx_ready;
    assign conn_open = (state == TX_OPEN);

    // Decide legality and the flit for the send command being presented.
    always_comb begin
        legal     = 1'b0;
        next_flit = '0;
        case (op)
            OP_SEND_HDR: begin
                legal     = (state == TX_IDLE) && (kind <= MAX_HDR_KIND);
                next_flit = make_header(opa_lo[NODE_W-1:0], kind, opb_lo);
            end
            OP_SEND_WORD: begin
                legal     = (state == TX_OPEN);
                next_flit = {1'b0, opa_lo};
            end
            OP_SEND_TAIL: begin
                legal     = (state == TX_OPEN);
                next_flit = TAIL_FLIT;
            end
            OP_SEND_ACK: begin
                legal     = 1'b1;
                next_flit = make_header(ack_dest, ACK_KIND, node_id);
            end
            default: begin
                legal     = 1'b0;
                next_flit = '0;
            end
        endcase
    end

    // Load the output slot on a legal send; release it when the router takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_flit  <= '0;
        end else if (launch && legal) begin
            tx_valid <= 1'b1;
            tx_flit  <= next_flit;
        end else if (tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    // Track the connection state and record the legality of each send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TX_IDLE;
            proto_err <= 1'b0;
        end else if (launch) begin
            proto_err <= !legal;
            if (legal && op == OP_SEND_HDR)  state <= TX_OPEN;
            if (legal && op == OP_SEND_TAIL) state <= TX_IDLE;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_flit)); // R6
    AST_TAIL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        launch && op == OP_SEND_TAIL && conn_open |=> !conn_open && tx_flit == TAIL_FLIT); // R4
    AST_IDLE_WORD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        launch && !conn_open && (op == OP_SEND_WORD || op == OP_SEND_TAIL)
        |=> proto_err && !conn_open && (tx_valid == $past(tx_valid && !tx_ready))); // R5
    AST_HDR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        launch && op == OP_SEND_HDR && !conn_open && kind <= MAX_HDR_KIND
        |=> conn_open && tx_valid && tx_flit[16] && !tx_flit[10]); // R1
endmodule

// File: rtl/mpni_packetizer.sv
// Network interface packetizer top.
// Decodes core commands, stalls them while they cannot complete, and routes
// sends to the send sequencer and reads to the receive FIFO, the node number
// or the flag vector. A read result is registered and valid for one cycle.
// It assumes the core holds a command steady while `busy` is high.
module mpni_packetizer
    import mpni_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RX_DEPTH   = 4,
    parameter int IMM_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        node_id,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [2:0]        cmd_kind,
    input  logic [DATA_W-1:0] cmd_opa,
    input  logic [DATA_W-1:0] cmd_opb,
    input  logic [IMM_W-1:0]  cmd_imm,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [16:0]       tx_flit,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [16:0]       rx_flit,
    input  logic              rx_valid,
    output logic              rx_ready
);
    localparam int FLAG_N = 7;
    localparam int SEL_W  = $clog2(FLAG_N);

    op_e               op;
    logic              is_send, is_read, accept, launch, pop;
    logic              slot_free, conn_open, proto_err, rx_empty;
    flit_t             rx_head;
    logic              cls_hdr, cls_tail, cls_data;
    logic [NODE_W-1:0] last_src;
    logic [FLAG_N-1:0] flag_vec;
    logic              flag_bit;
    logic [DATA_W-1:0] read_val;
    logic              unused_bits;

    assign unused_bits = ^{cmd_opa[DATA_W-1:WORD_W], cmd_opb[DATA_W-1:NODE_W]};

    assign op      = op_e'(cmd_op);
    assign is_send = (op == OP_SEND_HDR) || (op == OP_SEND_WORD) ||
                     (op == OP_SEND_TAIL) || (op == OP_SEND_ACK);
    assign is_read = (op == OP_RECV) || (op == OP_GET_ID) || (op == OP_GET_FLAG);

    // Decide whether the presented command can complete this cycle.
    always_comb begin
        if (!cmd_valid)          accept = 1'b0;
        else if (is_send)        accept = slot_free;
        else if (op == OP_RECV)  accept = !rx_empty;
        else                     accept = 1'b1;
    end

    assign busy   = cmd_valid && !accept;
    assign launch = accept && is_send;
    assign pop    = accept && (op == OP_RECV);

    mpni_tx_seq u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .op        (op),
        .kind      (cmd_kind),
        .opa_lo    (cmd_opa[WORD_W-1:0]),
        .opb_lo    (cmd_opb[NODE_W-1:0]),
        .ack_dest  (last_src),
        .node_id   (node_id),
        .tx_ready  (tx_ready),
        .tx_flit   (tx_flit),
        .tx_valid  (tx_valid),
        .slot_free (slot_free),
        .conn_open (conn_open),
        .proto_err (proto_err)
    );

    mpni_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(FLIT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (rx_flit),
        .in_valid (rx_valid),
        .in_ready (rx_ready),
        .pop      (pop),
        .head     (rx_head),
        .empty    (rx_empty)
    );

    // Classify each flit the core reads and keep the sender of the last header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_hdr  <= 1'b0;
            cls_tail <= 1'b0;
            cls_data <= 1'b0;
            last_src <= '0;
        end else if (pop) begin
            cls_data <= !rx_head[16];
            cls_tail <= rx_head[16] && rx_head[10];
            cls_hdr  <= rx_head[16] && !rx_head[10];
            if (rx_head[16] && !rx_head[10]) last_src <= rx_head[NODE_W-1:0];
        end
    end

    assign flag_vec = {tx_valid, cls_data, cls_tail, cls_hdr, proto_err, conn_open, !rx_empty};
    assign flag_bit = (cmd_imm < IMM_W'(FLAG_N)) ? flag_vec[cmd_imm[SEL_W-1:0]] : 1'b0;

    // Select the value a read command returns.
    always_comb begin
        case (op)
            OP_RECV:     read_val = {{(DATA_W-FLIT_W){1'b0}}, rx_head};
            OP_GET_ID:   read_val = {{(DATA_W-NODE_W){1'b0}}, node_id};
            OP_GET_FLAG: read_val = {{(DATA_W-1){1'b0}}, flag_bit};
            default:     read_val = '0;
        endcase
    end

    // Register the read result for one cycle after the command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= accept && is_read;
            if (accept && is_read) rd_data <= read_val;
        end
    end

    AST_RECV_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op == OP_RECV && rx_empty |-> busy); // R9
    AST_SEND_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && is_send && tx_valid && !tx_ready |-> busy); // R6
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cls_hdr, cls_tail, cls_data})); // R12
    AST_RD_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && !busy)); // R9
    AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op == OP_GET_ID |=> rd_valid && rd_data[NODE_W-1:0] == $past(node_id)); // R10
endmodule

// File: tb/mpni_packetizer_test.sv
// Scoreboard bench: driver tasks queue expected flits and read results,
// monitors pop and compare them as the design produces them.
module mpni_packetizer_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] MY_ID = 5'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0, cmd_kind = '0;
    logic [31:0] cmd_opa = '0, cmd_opb = '0;
    logic [3:0]  cmd_imm = '0;
    logic        busy, rd_valid, tx_valid, rx_ready;
    logic [31:0] rd_data;
    logic [16:0] tx_flit;
    logic        tx_ready = 1'b1;
    logic [16:0] rx_flit = '0;
    logic        rx_valid = 1'b0;

    int total = 0, bad = 0;
    bit stall_mode = 0;
    int rdy_cnt = 0;
    bit finished = 0;

    logic [16:0] tx_q[$];
    string       tx_tag[$];
    logic [31:0] rd_q[$];
    string       rd_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpni_packetizer uut (
        .clk(clk), .rst_n(rst_n), .node_id(MY_ID),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_kind(cmd_kind),
        .cmd_opa(cmd_opa), .cmd_opb(cmd_opb), .cmd_imm(cmd_imm),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .tx_flit(tx_flit), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_flit(rx_flit), .rx_valid(rx_valid), .rx_ready(rx_ready)
    );

    function automatic logic [16:0] hdr(input logic [4:0] d, input logic [2:0] k, input logic [4:0] s);
        return {1'b1, d, 3'b000, k, s};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Router readiness: always ready, or one cycle in three when stalling.
    always @(posedge clk) begin
        #1;
        rdy_cnt++;
        tx_ready = stall_mode ? (rdy_cnt % 3 == 0) : 1'b1;
    end

    // Output flit monitor: a flit transfers at the next edge when valid and ready.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (tx_q.size() == 0) begin
                chk(0, "R6 unexpected flit", {15'b0, tx_flit}, 32'h0);
            end else begin
                logic [16:0] e;
                string t;
                e = tx_q.pop_front();
                t = tx_tag.pop_front();
                chk(tx_flit == e, t, {15'b0, tx_flit}, {15'b0, e});
            end
        end
    end

    // Read result monitor.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (rd_q.size() == 0) begin
                chk(0, "R9 unexpected read result", rd_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = rd_q.pop_front();
                t = rd_tag.pop_front();
                chk(rd_data == e, t, rd_data, e);
            end
        end
    end

    // Present a command and hold it until accepted; called just after an edge.
    task automatic issue(input logic [2:0] op, input logic [2:0] kind,
                         input logic [31:0] a, input logic [31:0] b, input logic [3:0] imm);
        cmd_valid = 1'b1; cmd_op = op; cmd_kind = kind;
        cmd_opa = a; cmd_opb = b; cmd_imm = imm;
        @(negedge clk);
        while (busy) @(negedge clk);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic send_exp(input logic [2:0] op, input logic [2:0] kind,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [16:0] e, input string tag);
        tx_q.push_back(e); tx_tag.push_back(tag);
        issue(op, kind, a, b, 4'd0);
    endtask

    task automatic send_none(input logic [2:0] op, input logic [2:0] kind, input logic [31:0] a);
        issue(op, kind, a, 32'h0, 4'd0);
    endtask

    task automatic read_exp(input logic [2:0] op, input logic [3:0] imm,
                            input logic [31:0] e, input string tag);
        rd_q.push_back(e); rd_tag.push_back(tag);
        issue(op, 3'd0, 32'h0, 32'h0, imm);
    endtask

    task automatic flag_exp(input logic [3:0] idx, input bit v, input string tag);
        read_exp(3'd7, idx, {31'b0, v}, tag);
    endtask

    task automatic inject(input logic [16:0] f);
        rx_valid = 1'b1; rx_flit = f;
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(tx_valid == 0, "R6 reset tx_valid", {31'b0, tx_valid}, 0);
        chk(rx_ready == 1, "R8 reset rx_ready", {31'b0, rx_ready}, 1);
        chk(rd_valid == 0, "R9 reset rd_valid", {31'b0, rd_valid}, 0);
        @(posedge clk); #1;
        flag_exp(4'd3, 0, "R12 reset header class");
        flag_exp(4'd4, 0, "R12 reset tail class");
        flag_exp(4'd5, 0, "R12 reset data class");
        read_exp(3'd6, 4'd0, {27'b0, MY_ID}, "R10 get-id");

        // Word and tail in idle are rejected.
        send_none(3'd2, 3'd0, 32'h1234);
        flag_exp(4'd2, 1, "R5 error after idle word");
        send_none(3'd3, 3'd0, 32'h0);
        flag_exp(4'd2, 1, "R5 error after idle tail");
        flag_exp(4'd1, 0, "R11 still idle");

        // Open, repeat header, words, tail.
        send_exp(3'd1, 3'd2, 32'hFFFF_FFE3, 32'hABCD_0019, hdr(5'd3, 3'd2, 5'd25), "R1 header flit");
        flag_exp(4'd2, 0, "R5 error cleared by legal send");
        flag_exp(4'd1, 1, "R11 open flag");
        send_none(3'd1, 3'd1, 32'h4);
        flag_exp(4'd2, 1, "R2 header while open rejected");
        send_exp(3'd2, 3'd0, 32'h5A5A_BEEF, 32'h0, 17'h0BEEF, "R3 data flit");
        send_exp(3'd2, 3'd0, 32'hFFFF_0001, 32'h0, 17'h00001, "R3 data flit upper ignored");
        send_exp(3'd3, 3'd0, 32'h0, 32'h0, 17'h10400, "R4 tail flit");
        flag_exp(4'd1, 0, "R4 tail closes");
        flag_exp(4'd9, 0, "R11 out-of-range index");

        // Every kind under a stalling router.
        stall_mode = 1;
        for (int k = 0; k < 5; k++) begin
            send_exp(3'd1, 3'(k), 32'(k + 16), 32'h7, hdr(5'(k + 16), 3'(k), 5'd7), "R2 legal kind");
            send_exp(3'd2, 3'd0, 32'(k * 257), 32'h0, {1'b0, 16'(k * 257)}, "R6 word under stall");
            send_exp(3'd3, 3'd0, 32'h0, 32'h0, 17'h10400, "R6 tail under stall");
        end
        for (int k = 5; k < 8; k++) begin
            send_none(3'd1, 3'(k), 32'h2);
            flag_exp(4'd2, 1, "R2 illegal kind");
        end
        flag_exp(4'd1, 0, "R2 illegal kind leaves idle");
        stall_mode = 0;
        repeat (6) @(posedge clk); #1;

        // Fill the receive FIFO.
        inject(hdr(5'd9, 3'd1, 5'd17));
        inject(17'h01234);
        inject(17'h10400);
        inject(17'h00055);
        @(negedge clk);
        chk(rx_ready == 0, "R8 full deasserts ready", {31'b0, rx_ready}, 0);
        @(posedge clk); #1;
        flag_exp(4'd0, 1, "R11 data available");
        read_exp(3'd5, 4'd0, {15'b0, hdr(5'd9, 3'd1, 5'd17)}, "R8 first in order");
        flag_exp(4'd3, 1, "R12 header class");
        read_exp(3'd5, 4'd0, 32'h0000_1234, "R8 second in order");
        flag_exp(4'd5, 1, "R12 data class");
        flag_exp(4'd3, 0, "R12 header class cleared");
        read_exp(3'd5, 4'd0, 32'h0001_0400, "R8 third in order");
        flag_exp(4'd4, 1, "R12 tail class");
        read_exp(3'd5, 4'd0, 32'h0000_0055, "R8 fourth in order");
        flag_exp(4'd0, 0, "R11 drained");

        // Acknowledge to last header's sender.
        send_exp(3'd4, 3'd0, 32'h0, 32'h0, hdr(5'd17, 3'd7, MY_ID), "R7 ack flit");
        flag_exp(4'd1, 0, "R7 ack keeps idle");

        // Receive on empty stalls until a flit arrives.
        fork
            read_exp(3'd5, 4'd0, 32'h0000_0ABC, "R9 stalled receive");
            begin
                repeat (4) @(posedge clk);
                @(negedge clk);
                chk(busy == 1, "R9 busy on empty", {31'b0, busy}, 1);
                @(posedge clk); #1;
                inject(17'h00ABC);
            end
        join

        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(tx_q.size() == 0, "R6 all flits delivered", tx_q.size(), 0);
        chk(rd_q.size() == 0, "R9 all reads returned", rd_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule